// File: doc/BRIEF.md
# Reassembly Frame Discard Gate

This block sits on the receive side of an ATM reassembly engine, after channel lookup. For every arriving cell it decides whether the AAL5 frame that the cell belongs to is kept or thrown away as a whole. The inputs are the cell header fields, the resolved channel index with that channel's frame-relay discard-eligible mark and memory limit, status flags from the free-buffer and status-queue logic, and the fill level of the receive cell FIFO.

Several independent conditions can condemn a frame. Once a frame is condemned, every later cell of it on the same channel is dropped up to and including its last cell, and the next frame starts fresh. When several conditions hold on one cell, one reason is reported through a fixed priority. Idle cells are removed before any channel work. The block keeps per-cause tallies of condemned frames, a total of discarded PDUs, and a count of received non-idle cells.

Top module: `rx_frame_gate`

## Requirements
- R1: An idle cell (VPI=0, VCI=0, PTI=0, CLP=1) produces no verdict, leaves every counter unchanged and does not touch any channel's state.
- R2: A non-idle cell yields `verdValid` exactly one clock after it is presented; with no condition active it is kept (`verdKeep`=1, `verdReason`=0).
- R3: A cell that finds the receive FIFO full condemns its frame with reason 1.
- R4: A cell that finds the status queue overflowed condemns its frame with reason 2.
- R5: A cell that finds no free receive buffer condemns its frame with reason 3.
- R6: A cell whose frame cell count, this cell included, exceeds the channel's memory limit `chanFwLimit` condemns its frame with reason 4.
- R7: A cell whose frame cell count, this cell included, exceeds the global `maxPduCells` condemns its frame with reason 5.
- R8: A cell with CLP=1 condemns its frame with reason 6 when `fifoLevel` is strictly greater than `clpThresh`.
- R9: A cell on a channel with the discard-eligible mark condemns its frame with reason 7 when `fifoLevel` is strictly greater than `deThresh`.
- R10: When several conditions hold, the lowest reason code among them is reported (FIFO full first, CLP before DE last).
- R11: Cells of a condemned frame after the first are dropped with reason 8 regardless of the conditions, through the cell whose PTI has bit 2 clear and bit 0 set (end of frame); the next cell on that channel begins a new frame.
- R12: Each condemned frame adds one to the tally of its reason (tally for reason k in bits [(k-1)*CNT_W +: CNT_W] of `causeCnt`) and one to `pduDropCnt`; reason-8 cells add nothing; `rxCellCnt` counts every non-idle cell.
- R13: Channel state (condemned flag and cell count) is kept per channel, cleared at end of frame, and cells on one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellValid | input | 1 | A cell is presented this cycle |
| cellVpi | input | VPI_W | Cell VPI |
| cellVci | input | VCI_W | Cell VCI |
| cellPti | input | 3 | Cell payload type |
| cellClp | input | 1 | Cell loss priority bit |
| chanIdx | input | log2(NUM_CH) | Resolved channel index |
| chanDe | input | 1 | Channel carries the frame-relay discard-eligible mark |
| chanFwLimit | input | LEN_W | Channel memory limit in cells |
| bufEmpty | input | 1 | No free receive buffer |
| statOvf | input | 1 | Status queue overflowed |
| fifoFull | input | 1 | Receive cell FIFO full |
| fifoLevel | input | LVL_W | Receive FIFO occupancy |
| clpThresh | input | LVL_W | Occupancy threshold for CLP=1 cells |
| deThresh | input | LVL_W | Occupancy threshold for marked channels |
| maxPduCells | input | LEN_W | Global maximum frame length in cells |
| verdValid | output | 1 | Verdict strobe |
| verdKeep | output | 1 | Cell is kept |
| verdReason | output | 4 | 0 keep, 1..7 cause, 8 tail of condemned frame |
| causeCnt | output | 7*CNT_W | Per-cause condemned-frame tallies |
| pduDropCnt | output | CNT_W | Condemned PDUs in total |
| rxCellCnt | output | CNT_W | Non-idle cells received |

## Verification
The two functions that meet in one cycle are trigger arbitration and tail flushing: a cell that arrives in a condemned frame while fresh conditions such as a full FIFO also hold. The bench provokes this by asserting FIFO full again on the second cell of a frame already condemned, and by a cell with every condition active at once. It judges that the tail code 8 wins over any fresh cause and adds nothing to the tallies, and that the all-conditions cell reports code 1, with the final tallies compared against counts kept from the stimulus table.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  typedef enum logic [3:0] {
    RSN_NONE  = 4'd0,
    RSN_FIFO  = 4'd1,
    RSN_STATQ = 4'd2,
    RSN_NOBUF = 4'd3,
    RSN_FWALL = 4'd4,
    RSN_LEN   = 4'd5,
    RSN_CLP   = 4'd6,
    RSN_DE    = 4'd7,
    RSN_TAIL  = 4'd8
  } reason_e;

  localparam int NUM_CAUSE = 7;

  typedef struct packed {
    logic    verdict;
    logic    keep;
    logic    newDrop;
    logic    stWr;
    logic    stFlag;
    logic    cntClr;
    reason_e reason;
  } strobe_t;
endpackage

// File: rtl/rfg_ctrl.sv
module rfg_ctrl
  import rfg_pkg::*;
#(
  parameter int VPI_W = 12,
  parameter int VCI_W = 16,
  parameter int LEN_W = 11,
  parameter int LVL_W = 5
) (
  input  logic             cellValid,
  input  logic [VPI_W-1:0] cellVpi,
  input  logic [VCI_W-1:0] cellVci,
  input  logic [2:0]       cellPti,
  input  logic             cellClp,
  input  logic             chanDe,
  input  logic [LEN_W-1:0] chanFwLimit,
  input  logic             bufEmpty,
  input  logic             statOvf,
  input  logic             fifoFull,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] clpThresh,
  input  logic [LVL_W-1:0] deThresh,
  input  logic [LEN_W-1:0] maxPduCells,
  input  logic             rdFlag,
  input  logic [LEN_W-1:0] rdCnt,
  output strobe_t          stb
);
  logic          isIdle, take, isEom;
  logic [LEN_W:0] nextCnt;
  reason_e       cause;

  assign isIdle  = (cellVpi == '0) && (cellVci == '0) && (cellPti == 3'd0) && cellClp;
  assign take    = cellValid && !isIdle;
  assign isEom   = !cellPti[2] && cellPti[0];
  assign nextCnt = {1'b0, rdCnt} + 1'b1;

  // fixed priority among fresh causes
  always_comb begin
    if (fifoFull)                                   cause = RSN_FIFO;
    else if (statOvf)                               cause = RSN_STATQ;
    else if (bufEmpty)                              cause = RSN_NOBUF;
    else if (nextCnt > {1'b0, chanFwLimit})         cause = RSN_FWALL;
    else if (nextCnt > {1'b0, maxPduCells})         cause = RSN_LEN;
    else if (cellClp && (fifoLevel > clpThresh))    cause = RSN_CLP;
    else if (chanDe && (fifoLevel > deThresh))      cause = RSN_DE;
    else                                            cause = RSN_NONE;
  end

  always_comb begin
    stb        = '0;
    stb.reason = RSN_NONE;
    if (take) begin
      stb.verdict = 1'b1;
      stb.stWr    = 1'b1;
      if (rdFlag) begin
        stb.reason = RSN_TAIL;
        stb.stFlag = !isEom;
        stb.cntClr = 1'b1;
      end else if (cause != RSN_NONE) begin
        stb.reason  = cause;
        stb.newDrop = 1'b1;
        stb.stFlag  = !isEom;
        stb.cntClr  = 1'b1;
      end else begin
        stb.keep   = 1'b1;
        stb.cntClr = isEom;
      end
    end
  end
endmodule

// File: rtl/rfg_dpath.sv
module rfg_dpath
  import rfg_pkg::*;
#(
  parameter int NUM_CH = 1024,
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [CH_W-1:0]              chanIdx,
  output logic                         rdFlag,
  output logic [LEN_W-1:0]             rdCnt,
  output logic                         verdValid,
  output logic                         verdKeep,
  output logic [3:0]                   verdReason,
  output logic [NUM_CAUSE*CNT_W-1:0]   causeCnt,
  output logic [CNT_W-1:0]             pduDropCnt,
  output logic [CNT_W-1:0]             rxCellCnt
);
  logic             flagMem [NUM_CH];
  logic [LEN_W-1:0] cntMem  [NUM_CH];

  assign rdFlag = flagMem[chanIdx];
  assign rdCnt  = cntMem[chanIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        flagMem[i] <= 1'b0;
        cntMem[i]  <= '0;
      end
    end else if (stb.stWr) begin
      flagMem[chanIdx] <= stb.stFlag;
      cntMem[chanIdx]  <= stb.cntClr ? '0 : cntMem[chanIdx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdValid  <= 1'b0;
      verdKeep   <= 1'b0;
      verdReason <= '0;
      pduDropCnt <= '0;
      rxCellCnt  <= '0;
    end else begin
      verdValid  <= stb.verdict;
      verdKeep   <= stb.keep;
      verdReason <= stb.reason;
      if (stb.newDrop) pduDropCnt <= pduDropCnt + 1'b1;
      if (stb.verdict) rxCellCnt  <= rxCellCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_tally
    always_ff @(posedge clk) begin
      if (!rstN)
        causeCnt[g*CNT_W +: CNT_W] <= '0;
      else if (stb.newDrop && (stb.reason == reason_e'(g + 1)))
        causeCnt[g*CNT_W +: CNT_W] <= causeCnt[g*CNT_W +: CNT_W] + 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
  import rfg_pkg::*;
#(
  parameter int NUM_CH = 1024,
  parameter int VPI_W  = 12,
  parameter int VCI_W  = 16,
  parameter int LEN_W  = 11,
  parameter int LVL_W  = 5,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cellValid,
  input  logic [VPI_W-1:0]               cellVpi,
  input  logic [VCI_W-1:0]               cellVci,
  input  logic [2:0]                     cellPti,
  input  logic                           cellClp,
  input  logic [CH_W-1:0]                chanIdx,
  input  logic                           chanDe,
  input  logic [LEN_W-1:0]               chanFwLimit,
  input  logic                           bufEmpty,
  input  logic                           statOvf,
  input  logic                           fifoFull,
  input  logic [LVL_W-1:0]               fifoLevel,
  input  logic [LVL_W-1:0]               clpThresh,
  input  logic [LVL_W-1:0]               deThresh,
  input  logic [LEN_W-1:0]               maxPduCells,
  output logic                           verdValid,
  output logic                           verdKeep,
  output logic [3:0]                     verdReason,
  output logic [NUM_CAUSE*CNT_W-1:0]     causeCnt,
  output logic [CNT_W-1:0]               pduDropCnt,
  output logic [CNT_W-1:0]               rxCellCnt
);
  strobe_t          stb;
  logic             rdFlag;
  logic [LEN_W-1:0] rdCnt;

  rfg_ctrl #(.VPI_W(VPI_W), .VCI_W(VCI_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_ctrl (
    .cellValid(cellValid), .cellVpi(cellVpi), .cellVci(cellVci), .cellPti(cellPti),
    .cellClp(cellClp), .chanDe(chanDe), .chanFwLimit(chanFwLimit), .bufEmpty(bufEmpty),
    .statOvf(statOvf), .fifoFull(fifoFull), .fifoLevel(fifoLevel), .clpThresh(clpThresh),
    .deThresh(deThresh), .maxPduCells(maxPduCells), .rdFlag(rdFlag), .rdCnt(rdCnt),
    .stb(stb)
  );

  rfg_dpath #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .chanIdx(chanIdx), .rdFlag(rdFlag), .rdCnt(rdCnt),
    .verdValid(verdValid), .verdKeep(verdKeep), .verdReason(verdReason),
    .causeCnt(causeCnt), .pduDropCnt(pduDropCnt), .rxCellCnt(rxCellCnt)
  );

  // R1
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && cellVpi == '0 && cellVci == '0 && cellPti == 3'd0 && cellClp) |=> !verdValid);

  // R3
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && fifoFull) |=> !verdKeep);

  // R2
  keep_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdValid && verdKeep) |-> (verdReason == 4'd0));

  // R12
  drop_tally_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdValid && !verdKeep && verdReason != 4'd8) |-> (pduDropCnt == $past(pduDropCnt) + 1'b1));

  // R12
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(verdValid && !verdKeep && verdReason != 4'd8) |-> $stable(pduDropCnt));

  // R11
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdValid && verdReason == 4'd8) |-> (!verdKeep && $stable(causeCnt)));
endmodule

// File: tb/sim_rx_frame_gate.sv
module sim_rx_frame_gate;
  localparam int CNT_W = 16;
  localparam int NC    = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        cellValid = 0;
  logic [11:0] cellVpi = 0;
  logic [15:0] cellVci = 0;
  logic [2:0]  cellPti = 0;
  logic        cellClp = 0;
  logic [9:0]  chanIdx = 0;
  logic        chanDe = 0;
  logic [10:0] chanFwLimit = 11'd3;
  logic        bufEmpty = 0, statOvf = 0, fifoFull = 0;
  logic [4:0]  fifoLevel = 0;
  logic [4:0]  clpThresh = 5'd8, deThresh = 5'd12;
  logic [10:0] maxPduCells = 11'd4;
  logic        verdValid, verdKeep;
  logic [3:0]  verdReason;
  logic [NC*CNT_W-1:0] causeCnt;
  logic [CNT_W-1:0]    pduDropCnt, rxCellCnt;

  rx_frame_gate u0 (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellVpi(cellVpi), .cellVci(cellVci),
    .cellPti(cellPti), .cellClp(cellClp), .chanIdx(chanIdx), .chanDe(chanDe),
    .chanFwLimit(chanFwLimit), .bufEmpty(bufEmpty), .statOvf(statOvf), .fifoFull(fifoFull),
    .fifoLevel(fifoLevel), .clpThresh(clpThresh), .deThresh(deThresh),
    .maxPduCells(maxPduCells), .verdValid(verdValid), .verdKeep(verdKeep),
    .verdReason(verdReason), .causeCnt(causeCnt), .pduDropCnt(pduDropCnt),
    .rxCellCnt(rxCellCnt)
  );

  typedef struct packed {
    logic [3:0] ch;
    logic [2:0] pti;
    logic       clp, de, ff, so, be;
    logic [4:0] lvl;
    logic       keep;
    logic [3:0] rsn;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R2 first cell
    '{4'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R2 end of frame
    '{4'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 4'd1}, // R3
    '{4'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8}, // R11 tail wins over fresh cause
    '{4'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8}, // R11 last tail cell
    '{4'd2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R11 next frame kept
    '{4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0,  1'b0, 4'd2}, // R4 R10
    '{4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  1'b0, 4'd3}, // R5
    '{4'd4, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd8,  1'b1, 4'd0}, // R8 equal kept
    '{4'd4, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9,  1'b0, 4'd6}, // R8
    '{4'd4, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd12, 1'b1, 4'd0}, // R9 equal kept
    '{4'd4, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13, 1'b0, 4'd6}, // R10 CLP before DE
    '{4'd4, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd13, 1'b0, 4'd7}, // R9
    '{4'd5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R13
    '{4'd6, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 4'd1}, // R13 other channel drops
    '{4'd5, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R13 unaffected
    '{4'd6, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8}, // R13 tail
    '{4'd7, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R6 count 1
    '{4'd7, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R6 count 2
    '{4'd7, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R6 count 3
    '{4'd7, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd4}, // R6 count 4
    '{4'd7, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd8}, // R11
    '{4'd7, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R13 count restarted
    '{4'd7, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R11 pti 3 ends frame
    '{4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 4'd0}, // R13
    '{4'd8, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd31, 1'b0, 4'd1}  // R10 all causes
  };

  int errors = 0;
  int checks = 0;
  int sent   = 0;
  int expCause [NC];
  int expDrops = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendCell(input logic [9:0] ch, input logic [2:0] pti, input logic clp,
                          input logic de, input logic ff, input logic so, input logic be,
                          input logic [4:0] lvl, input bit idle);
    @(negedge clk);
    cellValid = 1; chanIdx = ch; cellPti = pti; cellClp = clp; chanDe = de;
    fifoFull = ff; statOvf = so; bufEmpty = be; fifoLevel = lvl;
    cellVpi = idle ? 12'd0 : 12'd1;
    cellVci = idle ? 16'd0 : 16'(32 + ch);
    if (!idle) sent++;
    @(posedge clk);
    @(negedge clk);
    cellValid = 0; fifoFull = 0; statOvf = 0; bufEmpty = 0; cellClp = 0; chanDe = 0;
  endtask

  task automatic expectCell(input string req, input logic keep, input logic [3:0] rsn);
    check(req, int'(verdValid), 1);
    check(req, int'(verdKeep), int'(keep));
    check(req, int'(verdReason), int'(rsn));
    if (!keep && rsn >= 4'd1 && rsn <= 4'd7) begin
      expCause[rsn - 1]++;
      expDrops++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) expCause[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset verdValid", int'(verdValid), 0);
    check("R12 reset pduDropCnt", int'(pduDropCnt), 0);
    check("R12 reset rxCellCnt", int'(rxCellCnt), 0);
    check("R12 reset causeCnt", int'(causeCnt == '0), 1);
    rstN = 1;

    for (int v = 0; v < NV; v++) begin
      sendCell(10'(VECS[v].ch), VECS[v].pti, VECS[v].clp, VECS[v].de, VECS[v].ff,
               VECS[v].so, VECS[v].be, VECS[v].lvl, 1'b0);
      expectCell($sformatf("R2..R13 vector %0d", v), VECS[v].keep, VECS[v].rsn);
    end

    // R1: idle cell with causes raised still yields nothing
    sendCell(10'd7, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1);
    check("R1 idle no verdict", int'(verdValid), 0);
    check("R1 idle rxCellCnt", int'(rxCellCnt), sent);
    check("R1 idle pduDropCnt", int'(pduDropCnt), expDrops);
    // R1: channel 7 untouched, so a clean single-cell frame is kept
    sendCell(10'd7, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    expectCell("R1 channel state untouched", 1'b1, 4'd0);

    // R7: length limit with a roomy firewall
    chanFwLimit = 11'd15;
    for (int k = 0; k < 4; k++) begin
      sendCell(10'd9, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
      expectCell("R7 within length", 1'b1, 4'd0);
    end
    sendCell(10'd9, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    expectCell("R7 over length", 1'b0, 4'd5);
    sendCell(10'd9, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    expectCell("R11 length tail", 1'b0, 4'd8);

    // R6 on a high channel index
    chanFwLimit = 11'd1;
    sendCell(10'd1000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    expectCell("R6 limit one first cell", 1'b1, 4'd0);
    sendCell(10'd1000, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0);
    expectCell("R6 limit one second cell", 1'b0, 4'd4);

    // R12 final tallies
    for (int i = 0; i < NC; i++)
      check($sformatf("R12 causeCnt reason %0d", i + 1),
            int'(causeCnt[i*CNT_W +: CNT_W]), expCause[i]);
    check("R12 pduDropCnt", int'(pduDropCnt), expDrops);
    check("R12 rxCellCnt", int'(rxCellCnt), sent);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule